// File: doc/BRIEF.md
# Minute-Start Synchronizer Controller

This controller watches two synchronous tone-present flags, one for the long 1 kHz burst that opens every minute and one for the short 100 Hz pulses that mark each second. It finds the top of the minute and tells a separate clock core to snap its seconds. It then hands control to a per-second decoder and waits. A burst only counts if it lasts long enough and no 100 Hz pulse appears while it plays. Second zero carries no 100 Hz pulse, so the first 100 Hz leading edge after a qualified burst is the start of second one. On that edge the controller fires a one-cycle seconds-set strobe, and the clock core loads the value one.

Once aligned, the controller raises the decoder enable. The decoder can ask for a fresh search, for example when a bit that must always read zero does not. It can also deliver a decoded hour and minute. A decoded time is applied in two steps. The controller first pulses the hours/minutes reset. It then issues exactly 60·hours + minutes minute-step pulses, one per clock, and holds a busy flag for the whole sequence. After a load, or after a resync request, the controller goes back to searching for the next minute burst. All durations are counted in ticks of a time-base strobe, so the timing parameters do not depend on the clock rate.

States: `ST_INIT` (power-up clear) → `ST_HUNT` (waiting for the 1 kHz flag) → `ST_BURST` (timing the burst) → `ST_ARMED` (waiting for a 100 Hz edge, with a timeout) → `ST_ALIGN` (seconds-set strobe) → `ST_RUN` (decoder enabled) → `ST_CLEAR` (hours/minutes reset) → `ST_STEP` (minute steps) → `ST_HUNT`.

Transitions:
- HUNT→BURST when the 1 kHz flag is high.
- BURST→HUNT when a 100 Hz flag appears, or when the burst ends too short.
- BURST→ARMED when a long enough burst ends.
- ARMED→ALIGN on a 100 Hz rising edge.
- ARMED→HUNT on timeout.
- RUN→HUNT on a resync request or on an out-of-range load.
- RUN→CLEAR on a valid load.
- CLEAR→HUNT when the step count is zero.
- CLEAR→STEP otherwise.
- STEP→HUNT after the last step.

Top module: `minute_sync_ctrl`

## Requirements
- R1: While reset is asserted, `sec_clear` and `hm_reset` are high and `sec_set`, `dec_en`, `min_step` and `busy` are low. After the first clock edge following release, all six outputs are low.
- R2: A 1 kHz burst is accepted only if, when the flag falls, more than `MIN_BURST_TICKS` ticks were counted while it was high. A shorter burst returns the controller to searching, and a later 100 Hz edge produces no `sec_set`.
- R3: A 100 Hz flag seen while a burst is being timed disqualifies that burst. The controller returns to searching.
- R4: After an accepted burst, the first rising edge of `tone_hz` causes `sec_set` to be high for exactly one cycle, in the cycle after the edge is sampled. `dec_en` is high from the following cycle on.
- R5: If no 100 Hz rising edge arrives within `TIMEOUT_TICKS` ticks after an accepted burst, the controller returns to searching. A later edge produces no `sec_set`.
- R6: `dec_en` is high only after alignment. A `resync_req` while enabled drops `dec_en` in the next cycle.
- R7: A `load_valid` with hours ≤ 23 and minutes ≤ 59 gives one `hm_reset` cycle with `busy` high. It is followed by exactly 60·hours + minutes consecutive `min_step` cycles, and `busy` stays high throughout. `busy` then falls and the controller is searching again.
- R8: A `load_valid` with hours > 23 or minutes > 59 gives no `hm_reset`, no `min_step` and no `busy`, and drops `dec_en`.
- R9: When `resync_req` and `load_valid` are high in the same cycle, the resync wins. No `hm_reset`, `min_step` or `busy` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe; all durations count these |
| tone_khz | input | 1 | 1 kHz tone present |
| tone_hz | input | 1 | 100 Hz tone present |
| resync_req | input | 1 | Decoder request to search again |
| load_valid | input | 1 | Decoded time is offered |
| load_hours | input | 5 | Decoded hours, binary |
| load_mins | input | 6 | Decoded minutes, binary |
| sec_clear | output | 1 | Clears the seconds counter at power-up |
| sec_set | output | 1 | Sets the seconds counter to one |
| hm_reset | output | 1 | Zeroes the hours and minutes counters |
| dec_en | output | 1 | Enables the per-second decoder |
| min_step | output | 1 | Advances the minutes counter by one |
| busy | output | 1 | Time load in progress |

## Verification
In the run state, the decoder can ask for a resync and offer a decoded time in the same cycle. This collision is provoked by holding both `resync_req` and `load_valid` high for one cycle, with an in-range time. The result is judged at the ports in the following cycles: `hm_reset`, `busy` and `min_step` must all stay low and `dec_en` must drop. This shows that the resync took priority and no partial load began.

// File: rtl/minute_sync_pkg.sv
package minute_sync_pkg;

    localparam int HOUR_W = 5;
    localparam int MIN_W  = 6;
    localparam int STEP_W = $clog2(24 * 60);

    typedef enum logic [2:0] {
        ST_INIT,
        ST_HUNT,
        ST_BURST,
        ST_ARMED,
        ST_ALIGN,
        ST_RUN,
        ST_CLEAR,
        ST_STEP
    } sync_state_e;

endpackage

// File: rtl/sync_tick_ctr.sv
module sync_tick_ctr #(
    parameter int CNT_MAX = 1200,
    localparam int CNT_W  = $clog2(CNT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    // Saturating up-counter; clear has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en && (cnt != CNT_W'(CNT_MAX))) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tone_rise_detect.sv
module tone_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    assign rise = level && !level_q;

endmodule

// File: rtl/hm_to_steps.sv
module hm_to_steps
    import minute_sync_pkg::*;
(
    input  logic [HOUR_W-1:0] hours,
    input  logic [MIN_W-1:0]  mins,
    output logic [STEP_W-1:0] steps,
    output logic              in_range
);

    // 60*h = 64*h - 4*h, avoids a general multiplier
    logic [STEP_W-1:0] h_ext;
    assign h_ext    = STEP_W'(hours);
    assign steps    = (h_ext << 6) - (h_ext << 2) + STEP_W'(mins);
    assign in_range = (hours < HOUR_W'(24)) && (mins < MIN_W'(60));

endmodule

// File: rtl/step_down_ctr.sv
module step_down_ctr
    import minute_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STEP_W-1:0] load_val,
    input  logic              dec,
    output logic [STEP_W-1:0] remain
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/minute_sync_ctrl.sv
module minute_sync_ctrl
    import minute_sync_pkg::*;
#(
    parameter int MIN_BURST_TICKS = 25,
    parameter int TIMEOUT_TICKS   = 1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tone_khz,
    input  logic              tone_hz,
    input  logic              resync_req,
    input  logic              load_valid,
    input  logic [HOUR_W-1:0] load_hours,
    input  logic [MIN_W-1:0]  load_mins,
    output logic              sec_clear,
    output logic              sec_set,
    output logic              hm_reset,
    output logic              dec_en,
    output logic              min_step,
    output logic              busy
);

    localparam int CNT_MAX = (TIMEOUT_TICKS > MIN_BURST_TICKS + 1) ?
                             TIMEOUT_TICKS : MIN_BURST_TICKS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sync_state_e       state, nxt;
    logic [CNT_W-1:0]  tcnt;
    logic              tcnt_clr, tcnt_en;
    logic              hz_rise;
    logic [STEP_W-1:0] ld_steps, remain;
    logic              ld_ok, ld_take;

    sync_tick_ctr #(.CNT_MAX(CNT_MAX)) u_tcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tcnt_clr),
        .en    (tcnt_en),
        .cnt   (tcnt)
    );

    tone_rise_detect u_hz_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (tone_hz),
        .rise  (hz_rise)
    );

    hm_to_steps u_conv (
        .hours    (load_hours),
        .mins     (load_mins),
        .steps    (ld_steps),
        .in_range (ld_ok)
    );

    step_down_ctr u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_take),
        .load_val (ld_steps),
        .dec      (state == ST_STEP),
        .remain   (remain)
    );

    assign ld_take  = (state == ST_RUN) && load_valid && !resync_req && ld_ok;
    assign tcnt_clr = (nxt != state);
    assign tcnt_en  = tick && (((state == ST_BURST) && tone_khz) ||
                               (state == ST_ARMED));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT:  nxt = ST_HUNT;
            ST_HUNT:  if (tone_khz) nxt = ST_BURST;
            ST_BURST: begin
                if (tone_hz) begin
                    nxt = ST_HUNT;
                end else if (!tone_khz) begin
                    nxt = (tcnt > CNT_W'(MIN_BURST_TICKS)) ? ST_ARMED : ST_HUNT;
                end
            end
            ST_ARMED: begin
                if (hz_rise) begin
                    nxt = ST_ALIGN;
                end else if (tcnt >= CNT_W'(TIMEOUT_TICKS)) begin
                    nxt = ST_HUNT;
                end
            end
            ST_ALIGN: nxt = ST_RUN;
            ST_RUN: begin
                if (resync_req) begin
                    nxt = ST_HUNT;
                end else if (load_valid) begin
                    nxt = ld_ok ? ST_CLEAR : ST_HUNT;
                end
            end
            ST_CLEAR: nxt = (remain == '0) ? ST_HUNT : ST_STEP;
            ST_STEP:  if (remain == STEP_W'(1)) nxt = ST_HUNT;
            default:  nxt = ST_HUNT;
        endcase
    end

    // Output decode
    always_comb begin
        sec_clear = 1'b0;
        sec_set   = 1'b0;
        hm_reset  = 1'b0;
        dec_en    = 1'b0;
        min_step  = 1'b0;
        busy      = 1'b0;
        unique case (state)
            ST_INIT: begin
                sec_clear = 1'b1;
                hm_reset  = 1'b1;
            end
            ST_ALIGN: sec_set = 1'b1;
            ST_RUN:   dec_en  = 1'b1;
            ST_CLEAR: begin
                hm_reset = 1'b1;
                busy     = 1'b1;
            end
            ST_STEP: begin
                min_step = 1'b1;
                busy     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/minute_sync_checker.sv
module minute_sync_checker (
    input logic clk,
    input logic rst_n,
    input logic tone_hz,
    input logic resync_req,
    input logic load_valid,
    input logic sec_set,
    input logic hm_reset,
    input logic dec_en,
    input logic min_step,
    input logic busy
);

    // R4: strobe is one cycle wide and follows a sampled rising edge
    assert_set_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_set |=> !sec_set);
    assert_set_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_set |-> ($past(tone_hz) && !$past(tone_hz, 2)));
    assert_enable_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_set |=> dec_en);

    // R6: resync drops the enable next cycle
    assert_resync_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && resync_req) |=> !dec_en);

    // R7: steps only inside a busy window, which opens with the reset strobe
    assert_step_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        min_step |-> busy);
    assert_busy_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> hm_reset);
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sec_set, hm_reset, min_step, dec_en}));

    // R9: collision never starts a load
    assert_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && resync_req && load_valid) |=> !busy);

endmodule

bind minute_sync_ctrl minute_sync_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone_hz    (tone_hz),
    .resync_req (resync_req),
    .load_valid (load_valid),
    .sec_set    (sec_set),
    .hm_reset   (hm_reset),
    .dec_en     (dec_en),
    .min_step   (min_step),
    .busy       (busy)
);

// File: tb/tb_minute_sync_ctrl.sv
module tb_minute_sync_ctrl;

    localparam int MINB = 5;
    localparam int TOUT = 12;
    localparam int NVEC = 6;

    // {hours[4:0], mins[5:0], expected steps[10:0], in range}
    localparam logic [22:0] VEC [NVEC] = '{
        {5'd0,  6'd0,  11'd0,    1'b1},
        {5'd1,  6'd5,  11'd65,   1'b1},
        {5'd23, 6'd59, 11'd1439, 1'b1},
        {5'd24, 6'd0,  11'd0,    1'b0},
        {5'd5,  6'd60, 11'd0,    1'b0},
        {5'd12, 6'd34, 11'd754,  1'b1}
    };

    logic clk = 1'b0;
    logic rst_n, tick, tone_khz, tone_hz, resync_req, load_valid;
    logic [4:0] load_hours;
    logic [5:0] load_mins;
    logic sec_clear, sec_set, hm_reset, dec_en, min_step, busy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    minute_sync_ctrl #(.MIN_BURST_TICKS(MINB), .TIMEOUT_TICKS(TOUT)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tone_khz(tone_khz),
        .tone_hz(tone_hz), .resync_req(resync_req), .load_valid(load_valid),
        .load_hours(load_hours), .load_mins(load_mins), .sec_clear(sec_clear),
        .sec_set(sec_set), .hm_reset(hm_reset), .dec_en(dec_en),
        .min_step(min_step), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Burst of len cycles, gap cycles of silence, then a 100 Hz edge.
    task automatic attempt(input int len, input int gap, input bit expect_set, input string req);
        @(negedge clk) tone_khz = 1'b1;
        repeat (len) @(negedge clk);
        tone_khz = 1'b0;
        repeat (gap) @(negedge clk);
        tone_hz = 1'b1;
        @(negedge clk);
        chk(sec_set == expect_set, req, int'(sec_set), int'(expect_set));
        @(negedge clk);
        chk(sec_set == 1'b0, req, int'(sec_set), 0);
        chk(dec_en == expect_set, req, int'(dec_en), int'(expect_set));
        tone_hz = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; tone_khz = 1'b0; tone_hz = 1'b0;
        resync_req = 1'b0; load_valid = 1'b0; load_hours = '0; load_mins = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sec_clear && hm_reset, "R1 clear strobes in reset", int'(sec_clear & hm_reset), 1);
        chk(!(sec_set | dec_en | min_step | busy), "R1 others low in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!(sec_clear | hm_reset | sec_set | dec_en | min_step | busy),
            "R1 outputs after release", int'(hm_reset), 0);

        // Vector table: align, then load a decoded time
        for (int i = 0; i < NVEC; i++) begin
            int steps;
            int exp_steps;
            bit ok_exp;
            exp_steps = int'(VEC[i][11:1]);
            ok_exp    = VEC[i][0];
            attempt(20, 3, 1'b1, "R4 alignment");
            load_hours = VEC[i][22:18];
            load_mins  = VEC[i][17:12];
            load_valid = 1'b1;
            @(negedge clk);
            load_valid = 1'b0;
            if (ok_exp) begin
                chk(hm_reset && busy && !min_step, "R7 reset cycle", int'(hm_reset), 1);
            end else begin
                chk(!hm_reset && !busy && !min_step && !dec_en, "R8 out-of-range load",
                    int'(hm_reset | busy), 0);
            end
            steps = 0;
            for (int c = 0; c < 1500; c++) begin
                if (!busy) break;
                @(negedge clk);
                if (min_step) steps++;
                if (hm_reset && busy) steps += 10000;
            end
            chk(steps == exp_steps, ok_exp ? "R7 step count" : "R8 no steps", steps, exp_steps);
            chk(!busy && !dec_en, "R7 back to search", int'(busy | dec_en), 0);
        end

        // R2: short burst is rejected
        attempt(3, 3, 1'b0, "R2 short burst");
        // R3: 100 Hz during burst disqualifies (rest of burst is short)
        @(negedge clk) tone_khz = 1'b1;
        repeat (17) @(negedge clk);
        tone_hz = 1'b1;
        @(negedge clk) tone_hz = 1'b0;
        repeat (2) @(negedge clk);
        tone_khz = 1'b0;
        repeat (3) @(negedge clk);
        tone_hz = 1'b1;
        @(negedge clk);
        chk(sec_set == 1'b0, "R3 pulse during burst", int'(sec_set), 0);
        @(negedge clk);
        chk(dec_en == 1'b0, "R3 no enable", int'(dec_en), 0);
        tone_hz = 1'b0;
        // R5: edge after timeout
        attempt(20, 25, 1'b0, "R5 timeout");
        // R6: resync drops enable
        attempt(20, 2, 1'b1, "R4 alignment");
        resync_req = 1'b1;
        @(negedge clk) resync_req = 1'b0;
        chk(dec_en == 1'b0, "R6 resync", int'(dec_en), 1'b0);
        // R9: resync and load in the same cycle
        attempt(20, 2, 1'b1, "R4 alignment");
        load_hours = 5'd2; load_mins = 6'd3;
        resync_req = 1'b1; load_valid = 1'b1;
        @(negedge clk);
        resync_req = 1'b0; load_valid = 1'b0;
        chk(!hm_reset && !busy && !dec_en, "R9 collision", int'(hm_reset | busy | dec_en), 0);
        @(negedge clk);
        chk(!min_step && !busy, "R9 no steps", int'(min_step | busy), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule